// File: doc/BRIEF.md
# USB Host Controller SMI Event Register

This block is a 32-bit status-and-enable register in a USB 2.0 host controller. It converts changes on controller control and status lines into a system management interrupt request. Edge detectors watch the controller's schedule enables, configure flag, halted indication and reset bit. A strobe marks software writes to the power-state field, and a per-port vector reports port-ownership events. Each event sets a sticky status bit, and software clears that bit by writing 1 to it. Every status bit has its own enable bit. The SMI output is high while any enabled status bit is set.

The only reset is `susp_rst`, which comes from the suspend power domain. A warm reset or a core-domain reset does not reach this block, so the recorded events and the enables survive both. Field layout: event enables in bits [5:0], port-owner enables in bits [8 +: NUM_PORTS], event status in bits [21:16], port-owner status in bits [24 +: NUM_PORTS]. The event index order inside both event fields is: 0 power-state write, 1 async schedule, 2 periodic schedule, 3 configure flag, 4 halted, 5 controller reset.

Top module: `usb_smi_evt_reg`

## Requirements
- R1: A synchronous high `susp_rst` clears all register bits and `smi_o`. Input levels present at release do not count as events, so after release `reg_rdata` reads 0.
- R2: Bit 17 (async), bit 18 (periodic) and bit 19 (configure flag) each become set when their input changes in either direction.
- R3: Bit 20 becomes set only when `hc_halted` goes from 0 to 1. A 1-to-0 change does not affect it.
- R4: Bit 21 becomes set only when `hc_reset` goes from 0 to 1. A 1-to-0 change does not affect it.
- R5: A one-cycle `pwr_state_wr` strobe sets bit 16.
- R6: A write with bit 1 in a status position clears that bit. A 0 leaves it unchanged, and status bits never clear without a write.
- R7: Bits [5:0] and [8 +: NUM_PORTS] are read/write enables that take `reg_wdata` on every write.
- R8: `smi_o` is 1 exactly when some status bit and its matching enable bit were both 1 at the previous clock edge.
- R9: `port_owner_evt[i]` high sets bit 24+i. Bit 24+i drives the SMI only when enable bit 8+i is 1.
- R10: When an event and a write-1-to-clear hit the same bit in one cycle, the bit stays set.
- R11: All bits outside the fields above read 0, and writes to them have no effect.
- R12: A status bit is set at the first clock edge that samples the input change. `reg_rdata` and `smi_o` reflect the register one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| susp_rst | input | 1 | Synchronous active-high suspend-domain reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Registered read data |
| pwr_state_wr | input | 1 | Strobe: software wrote the power-state field |
| async_sched_en | input | 1 | Async schedule enable level |
| periodic_sched_en | input | 1 | Periodic schedule enable level |
| cfg_flag | input | 1 | Configure flag level |
| hc_halted | input | 1 | Controller halted level |
| hc_reset | input | 1 | Controller reset level |
| port_owner_evt | input | NUM_PORTS | Per-port ownership event |
| smi_o | output | 1 | Registered SMI request |

## Verification
The either-edge inputs are toggled in both directions. The halted and controller-reset inputs get separate rising and falling transitions, which separates an either-edge detector from a rise-only one. Clear writes are sent with mixed 1 and 0 bits, and one clear lands in the same cycle as an event, which shows whether set or clear has priority. Port events are raised with only one port enabled, and inputs are held high through reset, to catch spurious events at release. A long random phase with sparse toggles and random writes is compared cycle by cycle with a bench model, which catches latency and field-position errors.

// File: rtl/usb_smi_pkg.sv
package usb_smi_pkg;
  localparam int EV_N     = 6;
  localparam int EV_PWR   = 0;
  localparam int EV_ASYNC = 1;
  localparam int EV_PER   = 2;
  localparam int EV_CFG   = 3;
  localparam int EV_HALT  = 4;
  localparam int EV_HCRST = 5;

  localparam int EN_LSB  = 0;
  localparam int PEN_LSB = 8;
  localparam int ST_LSB  = 16;
  localparam int PST_LSB = 24;

  localparam logic [EV_N-1:0] RISE_ONLY_MASK = 6'b110000;
endpackage

// File: rtl/usb_smi_edge_det.sv
module usb_smi_edge_det #(
  parameter bit RISE_ONLY = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  output logic evt
);
  logic prev_q;

  // Tracks the input during reset too, so release never produces an event.
  always_ff @(posedge clk) begin
    prev_q <= sig;
  end

  generate
    if (RISE_ONLY) begin : g_rise
      assign evt = !rst && sig && !prev_q;
    end else begin : g_any
      assign evt = !rst && (sig != prev_q);
    end
  endgenerate
endmodule

// File: rtl/usb_smi_w1c_bank.sv
module usb_smi_w1c_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] st_q
);
  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else     st_q <= (st_q & ~clr_i) | set_i;
  end
endmodule

// File: rtl/usb_smi_irq.sv
module usb_smi_irq #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] st_i,
  input  logic [W-1:0] en_i,
  output logic         smi_q
);
  always_ff @(posedge clk) begin
    if (rst) smi_q <= 1'b0;
    else     smi_q <= |(st_i & en_i);
  end
endmodule

// File: rtl/usb_smi_evt_reg.sv
module usb_smi_evt_reg
  import usb_smi_pkg::*;
#(
  parameter int NUM_PORTS = 6,  // at most 8
  parameter int REG_W     = 32
) (
  input  logic                 clk,
  input  logic                 susp_rst,
  input  logic                 reg_wr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic                 pwr_state_wr,
  input  logic                 async_sched_en,
  input  logic                 periodic_sched_en,
  input  logic                 cfg_flag,
  input  logic                 hc_halted,
  input  logic                 hc_reset,
  input  logic [NUM_PORTS-1:0] port_owner_evt,
  output logic                 smi_o
);
  localparam int SW = EV_N + NUM_PORTS;

  logic [EV_N-1:0] ev_raw, ev_set;
  logic [SW-1:0]   set_v, clr_v, st_q, en_all;
  logic [EV_N-1:0] en_ev_q;
  logic [NUM_PORTS-1:0] en_pt_q;
  logic [REG_W-1:0] rd_next;

  assign ev_raw = {hc_reset, hc_halted, cfg_flag, periodic_sched_en,
                   async_sched_en, pwr_state_wr};

  genvar gi;
  generate
    for (gi = 0; gi < EV_N; gi++) begin : g_ev
      if (gi == EV_PWR) begin : g_strobe
        assign ev_set[gi] = !susp_rst && ev_raw[gi];
      end else begin : g_det
        usb_smi_edge_det #(.RISE_ONLY(RISE_ONLY_MASK[gi])) u_det (
          .clk (clk),
          .rst (susp_rst),
          .sig (ev_raw[gi]),
          .evt (ev_set[gi])
        );
      end
    end
  endgenerate

  assign set_v = {port_owner_evt, ev_set};
  assign clr_v = reg_wr ? {reg_wdata[PST_LSB +: NUM_PORTS], reg_wdata[ST_LSB +: EV_N]}
                        : '0;

  usb_smi_w1c_bank #(.W(SW)) u_stat (
    .clk   (clk),
    .rst   (susp_rst),
    .set_i (set_v),
    .clr_i (clr_v),
    .st_q  (st_q)
  );

  always_ff @(posedge clk) begin
    if (susp_rst) begin
      en_ev_q <= '0;
      en_pt_q <= '0;
    end else if (reg_wr) begin
      en_ev_q <= reg_wdata[EN_LSB +: EV_N];
      en_pt_q <= reg_wdata[PEN_LSB +: NUM_PORTS];
    end
  end

  assign en_all = {en_pt_q, en_ev_q};

  usb_smi_irq #(.W(SW)) u_irq (
    .clk   (clk),
    .rst   (susp_rst),
    .st_i  (st_q),
    .en_i  (en_all),
    .smi_q (smi_o)
  );

  always_comb begin
    rd_next = '0;
    rd_next[EN_LSB  +: EV_N]      = en_ev_q;
    rd_next[PEN_LSB +: NUM_PORTS] = en_pt_q;
    rd_next[ST_LSB  +: EV_N]      = st_q[EV_N-1:0];
    rd_next[PST_LSB +: NUM_PORTS] = st_q[SW-1:EV_N];
  end

  always_ff @(posedge clk) begin
    if (susp_rst) reg_rdata <= '0;
    else          reg_rdata <= rd_next;
  end
endmodule

// File: rtl/usb_smi_evt_chk.sv
module usb_smi_evt_chk
  import usb_smi_pkg::*;
#(
  parameter int NUM_PORTS = 6,
  parameter int REG_W     = 32
) (
  input logic                      clk,
  input logic                      rst,
  input logic [EV_N+NUM_PORTS-1:0] st,
  input logic [EV_N+NUM_PORTS-1:0] en,
  input logic [EV_N+NUM_PORTS-1:0] set_v,
  input logic                      reg_wr,
  input logic                      async_in,
  input logic                      halt_in,
  input logic                      smi,
  input logic [REG_W-1:0]          rdata
);
  logic valid_q = 1'b0;
  logic [REG_W-1:0] live_mask;

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= 1'b1;
  end

  always_comb begin
    live_mask = '0;
    live_mask[EN_LSB  +: EV_N]      = '1;
    live_mask[PEN_LSB +: NUM_PORTS] = '1;
    live_mask[ST_LSB  +: EV_N]      = '1;
    live_mask[PST_LSB +: NUM_PORTS] = '1;
  end

  AST_SMI_MATCH: assert property (@(posedge clk) disable iff (rst || !valid_q)
    smi == $past(|(st & en))); // R8

  AST_ASYNC_SETS: assert property (@(posedge clk) disable iff (rst || !valid_q)
    (async_in != $past(async_in)) |=> st[EV_ASYNC]); // R2

  AST_HALT_FALL_QUIET: assert property (@(posedge clk) disable iff (rst || !valid_q)
    ($fell(halt_in) && !st[EV_HALT]) |=> !st[EV_HALT]); // R3

  AST_NO_SILENT_CLEAR: assert property (@(posedge clk) disable iff (rst || !valid_q)
    !reg_wr |=> ((st & $past(st)) == $past(st))); // R6

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (rst || !valid_q)
    (|set_v) |=> (($past(set_v) & ~st) == '0)); // R10

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst || !valid_q)
    (rdata & ~live_mask) == '0); // R11
endmodule

bind usb_smi_evt_reg usb_smi_evt_chk #(.NUM_PORTS(NUM_PORTS), .REG_W(REG_W)) u_chk (
  .clk      (clk),
  .rst      (susp_rst),
  .st       (st_q),
  .en       (en_all),
  .set_v    (set_v),
  .reg_wr   (reg_wr),
  .async_in (async_sched_en),
  .halt_in  (hc_halted),
  .smi      (smi_o),
  .rdata    (reg_rdata)
);

// File: tb/usb_smi_evt_reg_tb.sv
`timescale 1ns/1ps
module usb_smi_evt_reg_tb;
  localparam int NP = 6;
  localparam int W  = 32;
  localparam logic [31:0] EN_ALL = 32'h0000_3F3F;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic pwr = 0, asy = 0, per = 0, cfg = 0, hlt = 0, hrs = 0;
  logic [NP-1:0] pev = '0;
  logic smi;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model
  logic [5:0] m_en_ev = '0, m_st_ev = '0, m_prev = '0;
  logic [NP-1:0] m_en_pt = '0, m_st_pt = '0;
  logic [W-1:0] exp_rd = '0;
  logic exp_smi = 0;

  always #2 clk = ~clk;

  usb_smi_evt_reg #(.NUM_PORTS(NP), .REG_W(W)) u_dut (
    .clk(clk), .susp_rst(rst), .reg_wr(wr), .reg_wdata(wdata), .reg_rdata(rdata),
    .pwr_state_wr(pwr), .async_sched_en(asy), .periodic_sched_en(per),
    .cfg_flag(cfg), .hc_halted(hlt), .hc_reset(hrs), .port_owner_evt(pev), .smi_o(smi)
  );

  function automatic logic [W-1:0] pack_rd(input logic [5:0] ee, input logic [NP-1:0] ep,
                                           input logic [5:0] se, input logic [NP-1:0] sp);
    logic [W-1:0] r;
    r = '0;
    r[5:0] = ee;
    r[8 +: NP] = ep;
    r[21:16] = se;
    r[24 +: NP] = sp;
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock: model update at the edge, compare at the following falling edge
  task automatic cyc(input int n = 1);
    for (int k = 0; k < n; k++) begin
      logic [5:0] lv, setv;
      @(posedge clk);
      lv = {hrs, hlt, cfg, per, asy, pwr};
      if (rst) begin
        exp_rd = '0; exp_smi = 0;
        m_en_ev = '0; m_en_pt = '0; m_st_ev = '0; m_st_pt = '0;
      end else begin
        exp_rd  = pack_rd(m_en_ev, m_en_pt, m_st_ev, m_st_pt);
        exp_smi = |{m_st_ev & m_en_ev, m_st_pt & m_en_pt};
        setv[0] = pwr;
        setv[3:1] = lv[3:1] ^ m_prev[3:1];
        setv[5:4] = lv[5:4] & ~m_prev[5:4];
        if (wr) begin
          m_st_ev = m_st_ev & ~wdata[21:16];
          m_st_pt = m_st_pt & ~wdata[24 +: NP];
          m_en_ev = wdata[5:0];
          m_en_pt = wdata[8 +: NP];
        end
        m_st_ev = m_st_ev | setv;
        m_st_pt = m_st_pt | pev;
      end
      m_prev = lv;
      @(negedge clk);
      check("R12 model rdata", rdata, exp_rd);
      check("R8 model smi", {31'b0, smi}, {31'b0, exp_smi});
    end
  endtask

  task automatic wreg(input logic [W-1:0] d);
    wr = 1; wdata = d; cyc(1); wr = 0; wdata = '0;
  endtask

  initial begin
    // R1: inputs high during reset must not appear as events
    asy = 1; hlt = 1;
    cyc(3);
    rst = 0;
    cyc(2);
    check("R1 rdata after reset", rdata, 0);
    check("R1 smi after reset", {31'b0, smi}, 0);

    // R7 / R11
    wreg('1); cyc(1);
    check("R7 R11 enables readback", rdata, EN_ALL);

    // R2 / R12 async falling, latency
    asy = 0; cyc(1);
    check("R12 not yet visible", {31'b0, rdata[17]}, 0);
    cyc(1);
    check("R2 async fall sets bit17", {31'b0, rdata[17]}, 1);
    check("R8 smi asserted", {31'b0, smi}, 1);

    // R6 write 0 keeps, write 1 clears
    wreg(EN_ALL); cyc(1);
    check("R6 zero write keeps bit17", {31'b0, rdata[17]}, 1);
    wreg(EN_ALL | (32'h1 << 17)); cyc(1);
    check("R6 one write clears bit17", {31'b0, rdata[17]}, 0);
    check("R8 smi drops after clear", {31'b0, smi}, 0);

    // R3 halted
    hlt = 0; cyc(2);
    check("R3 halted fall ignored", {31'b0, rdata[20]}, 0);
    hlt = 1; cyc(2);
    check("R3 halted rise sets bit20", {31'b0, rdata[20]}, 1);

    // R4 controller reset
    hrs = 1; cyc(2);
    check("R4 reset rise sets bit21", {31'b0, rdata[21]}, 1);
    wreg(EN_ALL | (32'h1 << 21));
    hrs = 0; cyc(2);
    check("R4 reset fall ignored", {31'b0, rdata[21]}, 0);

    // R2 periodic and configure flag, rising
    per = 1; cfg = 1; cyc(2);
    check("R2 periodic rise sets bit18", {31'b0, rdata[18]}, 1);
    check("R2 cfg rise sets bit19", {31'b0, rdata[19]}, 1);

    // R5 power-state strobe
    pwr = 1; cyc(1); pwr = 0; cyc(1);
    check("R5 power strobe sets bit16", {31'b0, rdata[16]}, 1);

    // R10 event and clear in one cycle
    cfg = 0; wreg(EN_ALL | 32'h003F_0000); cyc(1);
    check("R10 event beats clear bit19", {31'b0, rdata[19]}, 1);
    check("R10 other bit cleared bit16", {31'b0, rdata[16]}, 0);

    // R9 port owner: only port 1 enabled
    wreg(32'h3F3F_0200); cyc(1);
    pev = 6'b000001; cyc(1); pev = '0; cyc(1);
    check("R9 port0 status set", {31'b0, rdata[24]}, 1);
    check("R9 port0 disabled no smi", {31'b0, smi}, 0);
    pev = 6'b000010; cyc(1); pev = '0; cyc(1);
    check("R9 port1 status set", {31'b0, rdata[25]}, 1);
    check("R9 port1 enabled smi", {31'b0, smi}, 1);

    // R1 reset in the middle of activity
    rst = 1; cyc(1); rst = 0; cyc(2);
    check("R1 mid-run reset clears", rdata, 0);

    // random phase against model
    void'($urandom(32'h5A17));
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 8 == 0) asy = ~asy;
      if ($urandom % 8 == 0) per = ~per;
      if ($urandom % 8 == 0) cfg = ~cfg;
      if ($urandom % 6 == 0) hlt = ~hlt;
      if ($urandom % 6 == 0) hrs = ~hrs;
      pwr = ($urandom % 10 == 0);
      pev = ($urandom % 5 == 0) ? NP'($urandom) : '0;
      wr = ($urandom % 4 == 0);
      wdata = $urandom;
      cyc(1);
    end
    wr = 0;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule